// File: doc/BRIEF.md
# Protected Flash Block Program Controller

This block sequences block-level programming work on a flash array organised in 64-byte blocks. A command arrives as one parameter set: an operation code (program one block, erase one block, or erase the whole array), two key bytes, a target block number, an SRAM source pointer with an SRAM page byte, and divider and settle values that set the timing of the high-voltage pulse. The controller first vets the command against a key byte, the block range and a per-block 2-bit protection mode. Only then does it touch the array. It also requires that a block be erased before it is programmed.

For a program command it streams 64 bytes out of an SRAM read port into the flash page buffer. It then waits a settle time and drives a program pulse whose width is set by the divider. Erase commands skip the streaming step. Every command ends with a one-cycle done strobe and three status bytes: an accumulator byte and two key bytes. A failed command returns a failure code in the first key byte and clears the other two bytes. Protection modes are loaded through a side port while the controller is idle. An erase of the whole array returns every block to the unprotected mode.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset, busy, done and all three status bytes are 0, every block is in protection mode 00 and every block counts as not erased.
- R2: A command whose first key byte is not 3Ah fails with first status key 02h, accumulator 00h and second status key 00h. It produces no pulse, and done rises in the second cycle after the accepting edge (latency 1).
- R3: A program or block-erase command with a block number of 80h or above fails with first status key 03h.
- R4: Protection modes are 00 open, 01 read-locked (writes allowed), 10 external writes barred (fails only when cmd_ext is 1) and 11 all writes barred. A barred program or erase fails with first status key 01h and with the accumulator and second key cleared to 00h.
- R5: Checks are applied in the order key, then range, then protection, then erased state. Only the first failing check sets the code.
- R6: A program command to a block that has not been erased since reset or since its last program fails with first status key 04h.
- R7: A program command reads SRAM address {page, (pointer + i) mod 256} for i = 0..63 in order, with one cycle of read latency. It writes byte i to page-buffer index i.
- R8: An accepted command waits dly+1 settle cycles and then holds its pulse for (div+1)*4 cycles. The pulse is fl_prog for program commands and fl_erase for erase commands, and fl_blk carries the block. Done follows the pulse after 2+dly+P edges for an erase and 67+dly+P edges for a program, where P is the pulse length.
- R9: On success the first status key is 00h, the accumulator holds the block number and the second key echoes the second key byte. Done lasts exactly one cycle, and busy is high from the cycle after acceptance through the done cycle.
- R10: Erase of the whole array is accepted for any block number and any protection mode. It sets fl_erase_all with the pulse, sets every block's mode to 00 and marks every block erased.
- R11: A successful block erase marks that block erased. A successful program marks it not erased.
- R12: cmd_valid and prot_set_en are ignored while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_op | input | 2 | 01 program, 10 erase block, 11 erase all, 00 no command |
| cmd_key_a | input | 8 | First key byte, must be 3Ah |
| cmd_key_b | input | 8 | Second key byte, echoed on success |
| cmd_blk | input | 8 | Target block number |
| cmd_ptr | input | 8 | SRAM offset of the first source byte |
| cmd_page | input | 8 | SRAM page of the source bytes |
| cmd_div | input | 8 | Pulse-width divider |
| cmd_dly | input | 8 | Settle count before the pulse |
| cmd_ext | input | 1 | 1 when the command comes from an external programmer |
| prot_set_en | input | 1 | Load a protection mode (idle only) |
| prot_set_blk | input | 7 | Block whose mode is loaded |
| prot_set_mode | input | 2 | Mode value to load |
| sram_rd_en | output | 1 | SRAM read request |
| sram_addr | output | 16 | SRAM read address {page, offset} |
| sram_rd_data | input | 8 | SRAM read data, one cycle after the request |
| fl_buf_we | output | 1 | Page-buffer write strobe |
| fl_buf_idx | output | 6 | Page-buffer byte index |
| fl_buf_data | output | 8 | Page-buffer write data |
| fl_blk | output | 7 | Block addressed by the pulse |
| fl_prog | output | 1 | Program pulse |
| fl_erase | output | 1 | Erase pulse |
| fl_erase_all | output | 1 | Erase pulse applies to the whole array |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle strobe, status valid |
| st_acc | output | 8 | Status accumulator byte |
| st_key1 | output | 8 | Status first key, 00h or failure code |
| st_key2 | output | 8 | Status second key |

## Verification
Commands are sent with a correct and an incorrect key, with block numbers inside and above the range, against each of the four protection modes from both origins, and against blocks that are erased or not yet erased. The result distinguishes each failure code from the others and tests the check priority. Programs use a source pointer near the top of a page, so the wrap of the offset inside the page is observed apart from a linear address. Divider and settle values vary from 0 to 56h, so the pulse length and the done latency separate the divider's effect from the settle delay's. Commands and protection loads are also sent while a command is running, and their absence is shown by the results of later commands.

// File: rtl/fps_pkg.sv
package fps_pkg;

  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [1:0] {
    OP_NONE      = 2'b00,
    OP_WRITE     = 2'b01,
    OP_ERASE     = 2'b10,
    OP_ERASE_ALL = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    PM_OPEN   = 2'b00,
    PM_RDLOCK = 2'b01,
    PM_NOEXT  = 2'b10,
    PM_NOINT  = 2'b11
  } prot_mode_e;

  localparam byte_t KEY_MAGIC = 8'h3A;
  localparam byte_t ST_OK     = 8'h00;
  localparam byte_t ST_PROT   = 8'h01;
  localparam byte_t ST_BADKEY = 8'h02;
  localparam byte_t ST_RANGE  = 8'h03;
  localparam byte_t ST_DIRTY  = 8'h04;

  // pulse length in cycles for a divider value
  function automatic int unsigned pulse_cycles(int unsigned div, int unsigned shift);
    return (div + 1) << shift;
  endfunction

  // true when the mode forbids a write or erase from the given origin
  function automatic logic write_barred(prot_mode_e mode, logic ext);
    return (mode == PM_NOINT) || ((mode == PM_NOEXT) && ext);
  endfunction

  // ordered command vetting: key, range, protection, erased state
  function automatic byte_t judge(op_e op, byte_t key_a, logic in_range,
                                  prot_mode_e mode, logic ext, logic erased);
    if (key_a != KEY_MAGIC) return ST_BADKEY;
    if (op != OP_ERASE_ALL) begin
      if (!in_range) return ST_RANGE;
      if (write_barred(mode, ext)) return ST_PROT;
    end
    if ((op == OP_WRITE) && !erased) return ST_DIRTY;
    return ST_OK;
  endfunction

endpackage

// File: rtl/fps_prot_table.sv
module fps_prot_table
  import fps_pkg::*;
#(
  parameter int NBLK = 128,
  localparam int IDX_W = $clog2(NBLK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  output prot_mode_e       lk_mode,
  output logic             lk_erased,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  prot_mode_e       set_mode,
  input  logic             mark_en,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             wipe
);

  prot_mode_e        mode_q [NBLK];
  logic [NBLK-1:0]   ers_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBLK; i++) mode_q[i] <= PM_OPEN;
      ers_q <= '0;
    end else if (wipe) begin
      for (int i = 0; i < NBLK; i++) mode_q[i] <= PM_OPEN;
      ers_q <= '1;
    end else begin
      if (set_en)  mode_q[set_idx] <= set_mode;
      if (mark_en) ers_q[upd_idx]  <= 1'b1;
      if (clr_en)  ers_q[upd_idx]  <= 1'b0;
    end
  end

  assign lk_mode   = mode_q[lk_idx];
  assign lk_erased = ers_q[lk_idx];

  // R10: after a whole-array erase any looked-up block is open and erased
  p_wipe_opens_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wipe) |-> (lk_mode == PM_OPEN) && lk_erased);

  // R11: mark and clear never requested together
  p_mark_clr_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mark_en && clr_en));

endmodule

// File: rtl/fps_stream.sv
module fps_stream #(
  parameter int NBYTES = 64,
  parameter int PTR_W  = 8,
  parameter int PAGE_W = 8,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(NBYTES),
  localparam int ADDR_W = PAGE_W + PTR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PTR_W-1:0]  base,
  input  logic [PAGE_W-1:0] page,
  output logic              sram_rd_en,
  output logic [ADDR_W-1:0] sram_addr,
  input  logic [DATA_W-1:0] sram_rd_data,
  output logic              buf_we,
  output logic [IDX_W-1:0]  buf_idx,
  output logic [DATA_W-1:0] buf_data,
  output logic              fin
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NBYTES - 1);

  logic             issuing;
  logic [IDX_W-1:0] idx;
  logic             we_q;
  logic [IDX_W-1:0] widx_q;

  // offset wraps inside the page
  function automatic logic [PTR_W-1:0] src_offset(logic [PTR_W-1:0] b, logic [IDX_W-1:0] i);
    return b + PTR_W'(i);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      issuing <= 1'b0;
      idx     <= '0;
      we_q    <= 1'b0;
      widx_q  <= '0;
    end else begin
      if (start) begin
        issuing <= 1'b1;
        idx     <= '0;
      end else if (issuing) begin
        idx <= idx + 1'b1;
        if (idx == LAST) issuing <= 1'b0;
      end
      we_q   <= issuing;
      widx_q <= idx;
    end
  end

  assign sram_rd_en = issuing;
  assign sram_addr  = {page, src_offset(base, idx)};
  assign buf_we     = we_q;
  assign buf_idx    = widx_q;
  assign buf_data   = sram_rd_data;
  assign fin        = we_q && (widx_q == LAST);

  // R7: buffer writes come in strictly rising index order without gaps
  p_buf_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_we && (buf_idx != LAST)) |=> buf_we && (buf_idx == $past(buf_idx) + 1'b1));

  // R12: a new stream only starts while the mover is quiet
  p_start_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !issuing && !buf_we);

endmodule

// File: rtl/fps_pulse_timer.sv
module fps_pulse_timer
  import fps_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int DLY_W = 8,
  parameter int SHIFT = 2,
  localparam int CNT_W = ((DIV_W + SHIFT + 1) > DLY_W) ? (DIV_W + SHIFT + 1) : DLY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIV_W-1:0] div,
  input  logic [DLY_W-1:0] dly,
  output logic             settle,
  output logic             pulse,
  output logic             fin
);

  typedef enum logic [1:0] {T_IDLE, T_SETTLE, T_PULSE} tstate_e;

  tstate_e          st;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= T_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        T_IDLE: if (start) begin
          st  <= T_SETTLE;
          cnt <= CNT_W'(dly);
        end
        T_SETTLE: if (cnt == '0) begin
          st  <= T_PULSE;
          cnt <= CNT_W'(pulse_cycles(32'(div), SHIFT) - 1);
        end else begin
          cnt <= cnt - 1'b1;
        end
        T_PULSE: if (cnt == '0) st <= T_IDLE;
                 else cnt <= cnt - 1'b1;
        default: st <= T_IDLE;
      endcase
    end
  end

  assign settle = (st == T_SETTLE);
  assign pulse  = (st == T_PULSE);
  assign fin    = pulse && (cnt == '0);

  // R8: a pulse is always preceded by the settle phase
  p_settle_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse) |-> $past(settle));

  // R12: the timer is only started when idle
  p_timer_start_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !settle && !pulse);

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import fps_pkg::*;
#(
  parameter int NBLK        = 128,
  parameter int NBYTES      = 64,
  parameter int PTR_W       = 8,
  parameter int PAGE_W      = 8,
  parameter int DIV_W       = 8,
  parameter int DLY_W       = 8,
  parameter int PULSE_SHIFT = 2,
  localparam int BIDX_W = $clog2(NBLK),
  localparam int IDX_W  = $clog2(NBYTES),
  localparam int ADDR_W = PAGE_W + PTR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [BYTE_W-1:0] cmd_key_a,
  input  logic [BYTE_W-1:0] cmd_key_b,
  input  logic [BYTE_W-1:0] cmd_blk,
  input  logic [PTR_W-1:0]  cmd_ptr,
  input  logic [PAGE_W-1:0] cmd_page,
  input  logic [DIV_W-1:0]  cmd_div,
  input  logic [DLY_W-1:0]  cmd_dly,
  input  logic              cmd_ext,
  input  logic              prot_set_en,
  input  logic [BIDX_W-1:0] prot_set_blk,
  input  logic [1:0]        prot_set_mode,
  output logic              sram_rd_en,
  output logic [ADDR_W-1:0] sram_addr,
  input  logic [BYTE_W-1:0] sram_rd_data,
  output logic              fl_buf_we,
  output logic [IDX_W-1:0]  fl_buf_idx,
  output logic [BYTE_W-1:0] fl_buf_data,
  output logic [BIDX_W-1:0] fl_blk,
  output logic              fl_prog,
  output logic              fl_erase,
  output logic              fl_erase_all,
  output logic              busy,
  output logic              done,
  output logic [BYTE_W-1:0] st_acc,
  output logic [BYTE_W-1:0] st_key1,
  output logic [BYTE_W-1:0] st_key2
);

  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_LOAD, S_TIME, S_DONE} state_e;

  state_e            state;
  op_e               op_q;
  byte_t             key_a_q, key_b_q, blk_q;
  logic [PTR_W-1:0]  ptr_q;
  logic [PAGE_W-1:0] page_q;
  logic [DIV_W-1:0]  div_q;
  logic [DLY_W-1:0]  dly_q;
  logic              ext_q;

  // named internal events
  logic       accept;
  logic       in_range;
  prot_mode_e lk_mode;
  logic       lk_erased;
  byte_t      chk_code;
  logic       chk_ok;
  logic       str_start, str_fin;
  logic       tmr_start, tmr_fin, tmr_settle, tmr_pulse;
  logic       tbl_set, tbl_mark, tbl_clr, tbl_wipe;

  assign accept    = (state == S_IDLE) && cmd_valid && (op_e'(cmd_op) != OP_NONE);
  assign in_range  = (32'(blk_q) < NBLK);
  assign chk_code  = judge(op_q, key_a_q, in_range, lk_mode, ext_q, lk_erased);
  assign chk_ok    = (chk_code == ST_OK);
  assign str_start = (state == S_CHECK) && chk_ok && (op_q == OP_WRITE);
  assign tmr_start = ((state == S_CHECK) && chk_ok && (op_q != OP_WRITE)) ||
                     ((state == S_LOAD) && str_fin);
  assign tbl_set   = prot_set_en && (state == S_IDLE);
  assign tbl_mark  = tmr_fin && (op_q == OP_ERASE);
  assign tbl_clr   = tmr_fin && (op_q == OP_WRITE);
  assign tbl_wipe  = tmr_fin && (op_q == OP_ERASE_ALL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      op_q    <= OP_NONE;
      key_a_q <= '0;
      key_b_q <= '0;
      blk_q   <= '0;
      ptr_q   <= '0;
      page_q  <= '0;
      div_q   <= '0;
      dly_q   <= '0;
      ext_q   <= 1'b0;
      st_acc  <= '0;
      st_key1 <= '0;
      st_key2 <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          op_q    <= op_e'(cmd_op);
          key_a_q <= cmd_key_a;
          key_b_q <= cmd_key_b;
          blk_q   <= cmd_blk;
          ptr_q   <= cmd_ptr;
          page_q  <= cmd_page;
          div_q   <= cmd_div;
          dly_q   <= cmd_dly;
          ext_q   <= cmd_ext;
          state   <= S_CHECK;
        end
        S_CHECK: begin
          if (!chk_ok) begin
            st_acc  <= '0;
            st_key1 <= chk_code;
            st_key2 <= '0;
            state   <= S_DONE;
          end else if (op_q == OP_WRITE) begin
            state <= S_LOAD;
          end else begin
            state <= S_TIME;
          end
        end
        S_LOAD: if (str_fin) state <= S_TIME;
        S_TIME: if (tmr_fin) begin
          st_acc  <= blk_q;
          st_key1 <= ST_OK;
          st_key2 <= key_b_q;
          state   <= S_DONE;
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  fps_prot_table #(.NBLK(NBLK)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_idx    (blk_q[BIDX_W-1:0]),
    .lk_mode   (lk_mode),
    .lk_erased (lk_erased),
    .set_en    (tbl_set),
    .set_idx   (prot_set_blk),
    .set_mode  (prot_mode_e'(prot_set_mode)),
    .mark_en   (tbl_mark),
    .clr_en    (tbl_clr),
    .upd_idx   (blk_q[BIDX_W-1:0]),
    .wipe      (tbl_wipe)
  );

  fps_stream #(
    .NBYTES(NBYTES), .PTR_W(PTR_W), .PAGE_W(PAGE_W), .DATA_W(BYTE_W)
  ) u_stream (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (str_start),
    .base         (ptr_q),
    .page         (page_q),
    .sram_rd_en   (sram_rd_en),
    .sram_addr    (sram_addr),
    .sram_rd_data (sram_rd_data),
    .buf_we       (fl_buf_we),
    .buf_idx      (fl_buf_idx),
    .buf_data     (fl_buf_data),
    .fin          (str_fin)
  );

  fps_pulse_timer #(
    .DIV_W(DIV_W), .DLY_W(DLY_W), .SHIFT(PULSE_SHIFT)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (tmr_start),
    .div    (div_q),
    .dly    (dly_q),
    .settle (tmr_settle),
    .pulse  (tmr_pulse),
    .fin    (tmr_fin)
  );

  assign busy         = (state != S_IDLE);
  assign done         = (state == S_DONE);
  assign fl_blk       = blk_q[BIDX_W-1:0];
  assign fl_prog      = tmr_pulse && (op_q == OP_WRITE);
  assign fl_erase     = tmr_pulse && (op_q != OP_WRITE);
  assign fl_erase_all = fl_erase && (op_q == OP_ERASE_ALL);

  // R9: done is a single-cycle strobe
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: done only occurs while busy
  p_done_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  // R4: any failure clears accumulator and second key
  p_fail_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (st_key1 != ST_OK)) |-> (st_acc == '0) && (st_key2 == '0));

  // R8: no pulse or array activity outside a running command
  p_pulse_in_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_prog || fl_erase || sram_rd_en || fl_buf_we) |-> busy && !done);

  // R2: a rejected command never leads to a pulse before done
  p_fail_no_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_CHECK) && !chk_ok) |=> done && !fl_prog && !fl_erase);

endmodule

// File: tb/tb_flash_prog_seq.sv
module tb_flash_prog_seq;
  import fps_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'b00;
  logic [7:0]  cmd_key_a = 8'h00, cmd_key_b = 8'h00, cmd_blk = 8'h00;
  logic [7:0]  cmd_ptr = 8'h00, cmd_page = 8'h00, cmd_div = 8'h00, cmd_dly = 8'h00;
  logic        cmd_ext = 1'b0;
  logic        prot_set_en = 1'b0;
  logic [6:0]  prot_set_blk = 7'h0;
  logic [1:0]  prot_set_mode = 2'b00;
  logic        sram_rd_en;
  logic [15:0] sram_addr;
  logic [7:0]  sram_rd_data = 8'h00;
  logic        fl_buf_we;
  logic [5:0]  fl_buf_idx;
  logic [7:0]  fl_buf_data;
  logic [6:0]  fl_blk;
  logic        fl_prog, fl_erase, fl_erase_all;
  logic        busy, done;
  logic [7:0]  st_acc, st_key1, st_key2;

  flash_prog_seq dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_key_a(cmd_key_a), .cmd_key_b(cmd_key_b),
    .cmd_blk(cmd_blk), .cmd_ptr(cmd_ptr), .cmd_page(cmd_page), .cmd_div(cmd_div),
    .cmd_dly(cmd_dly), .cmd_ext(cmd_ext),
    .prot_set_en(prot_set_en), .prot_set_blk(prot_set_blk), .prot_set_mode(prot_set_mode),
    .sram_rd_en(sram_rd_en), .sram_addr(sram_addr), .sram_rd_data(sram_rd_data),
    .fl_buf_we(fl_buf_we), .fl_buf_idx(fl_buf_idx), .fl_buf_data(fl_buf_data),
    .fl_blk(fl_blk), .fl_prog(fl_prog), .fl_erase(fl_erase), .fl_erase_all(fl_erase_all),
    .busy(busy), .done(done), .st_acc(st_acc), .st_key1(st_key1), .st_key2(st_key2)
  );

  // 100 MHz: 10 time-unit period
  always #5 clk = ~clk;

  int checks = 0;
  int errs = 0;
  int cyc = 0;
  int t_acc = 0;
  int pcnt = 0;
  int allcnt = 0;
  logic [6:0] last_blk = 7'h0;
  logic [7:0] pbuf [64];
  logic [1:0] pm [128];
  bit         em [128];

  typedef struct {
    logic [7:0] k1, acc, k2;
    int         lat, pulses;
    bit         ok, wr, chk_blk, all;
    logic [7:0] blk, ptr, page;
    string      tag;
  } exp_t;
  exp_t sb [$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] sram_f(logic [15:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ 8'hC3;
  endfunction

  // behavioural SRAM, one cycle read latency
  always @(posedge clk) sram_rd_data <= sram_rd_en ? sram_f(sram_addr) : 8'h00;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] model_code(logic [1:0] op, logic [7:0] ka,
                                            logic [7:0] blk, bit ext);
    if (ka != 8'h3A) return 8'h02;
    if (op != 2'b11) begin
      if (blk >= 8'h80) return 8'h03;
      if (pm[blk[6:0]] == 2'b11 || (pm[blk[6:0]] == 2'b10 && ext)) return 8'h01;
    end
    if (op == 2'b01 && !em[blk[6:0]]) return 8'h04;
    return 8'h00;
  endfunction

  // monitor: pops scoreboard at each done
  always @(negedge clk) begin
    if (rst_n) begin
      if (fl_prog || fl_erase) begin
        pcnt++;
        last_blk = fl_blk;
        if (fl_erase_all) allcnt++;
      end
      if (fl_buf_we) pbuf[fl_buf_idx] = fl_buf_data;
      if (done) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R12", "unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(st_key1 == e.k1, e.tag, "key1", st_key1, e.k1);
          chk(st_acc == e.acc, e.tag, "acc", st_acc, e.acc);
          chk(st_key2 == e.k2, e.tag, "key2", st_key2, e.k2);
          chk((cyc - t_acc) == e.lat, "R8", "latency", cyc - t_acc, e.lat);
          chk(pcnt == e.pulses, "R8", "pulse cycles", pcnt, e.pulses);
          chk(busy == 1'b1, "R9", "busy at done", busy, 1);
          if (e.ok && e.chk_blk)
            chk(last_blk == e.blk[6:0], "R8", "pulse block", last_blk, e.blk[6:0]);
          if (e.ok && e.all)
            chk(allcnt == e.pulses, "R10", "erase-all flag cycles", allcnt, e.pulses);
          if (e.ok && e.wr) begin
            int bad;
            bad = 0;
            for (int i = 0; i < 64; i++) begin
              logic [7:0] off;
              off = e.ptr + 8'(i);
              if (pbuf[i] !== sram_f({e.page, off})) bad++;
            end
            chk(bad == 0, "R7", "streamed bytes mismatching", bad, 0);
          end
        end
      end
    end
  end

  task automatic run(input logic [1:0] op, input logic [7:0] ka, input logic [7:0] kb,
                     input logic [7:0] blk, input logic [7:0] ptr, input logic [7:0] page,
                     input logic [7:0] div, input logic [7:0] dly, input bit ext,
                     input string tag);
    exp_t e;
    logic [7:0] code;
    int p;
    code = model_code(op, ka, blk, ext);
    p = (int'(div) + 1) * 4;
    e.k1 = code;
    e.ok = (code == 8'h00);
    e.acc = e.ok ? blk : 8'h00;
    e.k2 = e.ok ? kb : 8'h00;
    e.pulses = e.ok ? p : 0;
    e.lat = !e.ok ? 1 : ((op == 2'b01) ? 67 + int'(dly) + p : 2 + int'(dly) + p);
    e.wr = (op == 2'b01);
    e.all = (op == 2'b11);
    e.chk_blk = (op != 2'b11);
    e.blk = blk; e.ptr = ptr; e.page = page; e.tag = tag;
    for (int i = 0; i < 64; i++) pbuf[i] = 8'hxx;
    sb.push_back(e);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_key_a = ka; cmd_key_b = kb; cmd_blk = blk;
    cmd_ptr = ptr; cmd_page = page; cmd_div = div; cmd_dly = dly; cmd_ext = ext;
    pcnt = 0;
    allcnt = 0;
    @(negedge clk);
    cmd_valid = 1'b0;
    t_acc = cyc;
    chk(busy == 1'b1, "R9", "busy after accept", busy, 1);
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done single cycle", done, 0);
    if (e.ok) begin
      if (op == 2'b01) em[blk[6:0]] = 1'b0;
      if (op == 2'b10) em[blk[6:0]] = 1'b1;
      if (op == 2'b11) for (int i = 0; i < 128; i++) begin pm[i] = 2'b00; em[i] = 1'b1; end
    end
  endtask

  task automatic set_prot(input logic [6:0] b, input logic [1:0] m);
    @(negedge clk);
    prot_set_en = 1'b1; prot_set_blk = b; prot_set_mode = m;
    @(negedge clk);
    prot_set_en = 1'b0;
    pm[b] = m;
  endtask

  // stimulus while busy: must have no effect (R12)
  task automatic poke_busy();
    repeat (5) @(negedge clk);
    chk(busy == 1'b1, "R12", "busy during poke", busy, 1);
    cmd_valid = 1'b1; cmd_op = 2'b11; cmd_key_a = 8'h3A; cmd_blk = 8'h00;
    prot_set_en = 1'b1; prot_set_blk = 7'd20; prot_set_mode = 2'b11;
    @(negedge clk);
    cmd_valid = 1'b0;
    prot_set_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) begin pm[i] = 2'b00; em[i] = 1'b0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
    chk(done == 1'b0, "R1", "done after reset", done, 0);
    chk(st_key1 == 8'h00 && st_acc == 8'h00 && st_key2 == 8'h00, "R1",
        "status after reset", {st_acc, st_key1, st_key2}, 0);

    // R1, R6: fresh block not erased
    run(2'b01, 8'h3A, 8'h11, 8'h03, 8'h00, 8'h01, 8'h01, 8'h00, 1'b0, "R6");
    // R2: bad key
    run(2'b01, 8'h3B, 8'h11, 8'h03, 8'h00, 8'h01, 8'h01, 8'h00, 1'b0, "R2");
    // R5: key checked before range
    run(2'b10, 8'h00, 8'h22, 8'h90, 8'h00, 8'h00, 8'h01, 8'h00, 1'b0, "R5");
    // R3: range
    run(2'b10, 8'h3A, 8'h22, 8'h80, 8'h00, 8'h00, 8'h01, 8'h00, 1'b0, "R3");
    run(2'b01, 8'h3A, 8'h22, 8'hFF, 8'h00, 8'h00, 8'h01, 8'h00, 1'b0, "R3");
    // R11, R8: erase then program, program again fails
    run(2'b10, 8'h3A, 8'h5C, 8'h03, 8'h00, 8'h00, 8'h03, 8'h02, 1'b0, "R11");
    run(2'b01, 8'h3A, 8'h6D, 8'h03, 8'hF0, 8'h12, 8'h01, 8'h00, 1'b0, "R9");
    run(2'b01, 8'h3A, 8'h6D, 8'h03, 8'h10, 8'h12, 8'h01, 8'h00, 1'b0, "R11");
    // R4: mode 10 per origin, mode 01 permits writes
    set_prot(7'd10, 2'b10);
    run(2'b10, 8'h3A, 8'h01, 8'h0A, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, "R4");
    run(2'b10, 8'h3A, 8'h01, 8'h0A, 8'h00, 8'h00, 8'h00, 8'h01, 1'b0, "R4");
    set_prot(7'd11, 2'b01);
    run(2'b10, 8'h3A, 8'h02, 8'h0B, 8'h00, 8'h00, 8'h02, 8'h00, 1'b1, "R4");
    run(2'b01, 8'h3A, 8'h03, 8'h0B, 8'h80, 8'hA5, 8'h00, 8'h03, 1'b1, "R4");
    // R4, R5: mode 11 bars both origins; protection reported before erased state
    set_prot(7'd12, 2'b11);
    run(2'b10, 8'h3A, 8'h04, 8'h0C, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, "R4");
    run(2'b01, 8'h3A, 8'h04, 8'h0C, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, "R5");
    // R12: commands and protection loads while busy are dropped
    fork
      run(2'b10, 8'h3A, 8'h07, 8'h14, 8'h00, 8'h00, 8'h14, 8'h03, 1'b0, "R12");
      poke_busy();
    join
    run(2'b01, 8'h3A, 8'h08, 8'h15, 8'h00, 8'h02, 8'h00, 8'h00, 1'b0, "R12");
    run(2'b10, 8'h3A, 8'h09, 8'h14, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, "R12");
    // R10: erase all ignores block and protection, clears protection
    run(2'b11, 8'h3A, 8'h0E, 8'hFF, 8'h00, 8'h00, 8'h56, 8'h05, 1'b1, "R10");
    run(2'b10, 8'h3A, 8'h0F, 8'h0C, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, "R10");
    run(2'b01, 8'h3A, 8'h33, 8'h32, 8'hC7, 8'h7E, 8'h02, 8'h01, 1'b0, "R10");
    run(2'b11, 8'h00, 8'h0E, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, "R2");

    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R12", "pending results", sb.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

endmodule